// File: doc/BRIEF.md
# Event and Alarm Interrupt Controller

This block combines two interrupt sources onto one shared active-low, open-drain request line. The first source is an asynchronous external event input. A high level on it is treated as a detected event. The second source is a single-cycle alarm-match strobe that comes from a comparator elsewhere in the chip. Each source has its own sticky status flag, so the host can tell which one raised the request. The host clears a flag by writing a 1 to its bit.

A three-bit control register sets the behaviour:
- one bit enables event detection;
- one bit allows detection to keep running while the supply controller reports battery-backup operation;
- one bit lets the alarm flag drive the shared line.

The line is modelled as a pull-down enable. It is released whenever no qualified flag is set.

Top module: `evt_irq_ctrl`

## Requirements
- R1: A synchronous active-high reset clears both status flags and all three control bits, and releases the interrupt line (`irq_pull_low` = 0).
- R2: The event input passes through a two-flop synchroniser. With detection enabled, the event flag (`status_q[0]`) becomes 1 on the third rising edge after the input goes high, and not before.
- R3: While the event-enable bit (`ctrl_q[0]`) is 0, no level on the event input can set the event flag.
- R4: While `on_battery` is 1 and the battery-detect bit (`ctrl_q[1]`) is 0, events are ignored. With that bit at 1, events are detected on battery as they are on main supply.
- R5: A set event flag, with event detection enabled, pulls the interrupt line low. The line stays low after the input returns low, until the host clears the flag.
- R6: An alarm strobe sets the alarm flag (`status_q[1]`) on the next edge, whatever the control bits are.
- R7: Writes with `wr_sel` = 1 clear each status flag whose data bit is 1 (bit 0 for event, bit 1 for alarm). Zero bits leave their flags unchanged. When a set condition and a clear of the same flag occur in the same cycle, the flag stays set.
- R8: The two flags are independent: clearing one leaves the other unchanged.
- R9: Writes with `wr_sel` = 0 load `wr_data` into the control register, which reads back on `ctrl_q`. Bit 0 is event enable, bit 1 is battery detect, bit 2 is alarm line enable.
- R10: `irq_pull_low` is 1 exactly when (event flag AND event enable) OR (alarm flag AND alarm line enable). A set alarm flag with its enable at 0 leaves the line released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous reset, active high |
| evt_in | input | 1 | Asynchronous external event level |
| alarm_strobe | input | 1 | One-cycle alarm-match pulse |
| on_battery | input | 1 | Supply controller reports battery-backup operation |
| wr_en | input | 1 | Host register write strobe |
| wr_sel | input | 1 | Write target: 0 control, 1 status clear |
| wr_data | input | 3 | Write data |
| ctrl_q | output | 3 | Control register contents |
| status_q | output | 2 | Sticky flags: bit 0 event, bit 1 alarm |
| irq_pull_low | output | 1 | Pull-down enable of the shared open-drain line |

## Verification
The assertions check these properties on every cycle:
- the line stays released while no flag is set;
- a disabled or battery-gated event never sets the flag;
- a set flag holds unless it receives an explicit clear;
- a qualified event or an alarm strobe always sets its flag, even against a simultaneous clear.

Only the bench scenarios can show the following:
- the exact three-edge latency from the raw input to the flag;
- that detection resumes correctly when the battery-detect bit is set;
- that the two flags are cleared independently;
- the full combination of control bits, supply state and sources in the vector table.

// File: rtl/evt_irq_pkg.sv
package evt_irq_pkg;

  localparam int CTRL_W       = 3;
  localparam int CTRL_EVT_EN  = 0;
  localparam int CTRL_BATT_OK = 1;
  localparam int CTRL_ALM_EN  = 2;

  localparam int NFLAG    = 2;
  localparam int FLAG_EVT = 0;
  localparam int FLAG_ALM = 1;

  localparam int SYNC_STAGES = 2;

  // An event counts when seen, enabled and not blocked by battery gating.
  function automatic logic event_qualifies(input logic seen,
                                           input logic [CTRL_W-1:0] ctrl,
                                           input logic batt);
    return seen && ctrl[CTRL_EVT_EN] && (!batt || ctrl[CTRL_BATT_OK]);
  endfunction

  // Shared line request from flags and enables.
  function automatic logic line_request(input logic [NFLAG-1:0] flags,
                                        input logic [CTRL_W-1:0] ctrl);
    return (flags[FLAG_EVT] && ctrl[CTRL_EVT_EN]) ||
           (flags[FLAG_ALM] && ctrl[CTRL_ALM_EN]);
  endfunction

endpackage

// File: rtl/evt_sync.sv
module evt_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain <= '0;
    else     chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/evt_ctrl_reg.sv
module evt_ctrl_reg
  import evt_irq_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [CTRL_W-1:0] din,
  output logic [CTRL_W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst)       q <= '0;
    else if (load) q <= din;
  end
endmodule

// File: rtl/evt_flag_bank.sv
module evt_flag_bank #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] set_vec,
  input  logic [N-1:0] clr_vec,
  output logic [N-1:0] flags
);
  for (genvar i = 0; i < N; i++) begin : g_flag
    always_ff @(posedge clk) begin
      if (rst)             flags[i] <= 1'b0;
      else if (set_vec[i]) flags[i] <= 1'b1;   // set wins over clear
      else if (clr_vec[i]) flags[i] <= 1'b0;
    end
  end
endmodule

// File: rtl/evt_irq_ctrl.sv
module evt_irq_ctrl
  import evt_irq_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              evt_in,
  input  logic              alarm_strobe,
  input  logic              on_battery,
  input  logic              wr_en,
  input  logic              wr_sel,
  input  logic [CTRL_W-1:0] wr_data,
  output logic [CTRL_W-1:0] ctrl_q,
  output logic [NFLAG-1:0]  status_q,
  output logic              irq_pull_low
);
  logic             evt_seen;
  logic             evt_qual;
  logic             ctrl_load;
  logic [NFLAG-1:0] flag_set;
  logic [NFLAG-1:0] flag_clr;

  evt_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .d(evt_in), .q(evt_seen)
  );

  assign ctrl_load = wr_en && !wr_sel;

  evt_ctrl_reg u_ctrl (
    .clk(clk), .rst(rst), .load(ctrl_load), .din(wr_data), .q(ctrl_q)
  );

  assign evt_qual = event_qualifies(evt_seen, ctrl_q, on_battery);

  always_comb begin
    flag_set           = '0;
    flag_set[FLAG_EVT] = evt_qual;
    flag_set[FLAG_ALM] = alarm_strobe;
    flag_clr           = (wr_en && wr_sel) ? wr_data[NFLAG-1:0] : '0;
  end

  evt_flag_bank #(.N(NFLAG)) u_flags (
    .clk(clk), .rst(rst), .set_vec(flag_set), .clr_vec(flag_clr),
    .flags(status_q)
  );

  assign irq_pull_low = line_request(status_q, ctrl_q);
endmodule

// File: rtl/evt_irq_ctrl_chk.sv
module evt_irq_ctrl_chk
  import evt_irq_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic              alarm_strobe,
  input logic              on_battery,
  input logic              wr_en,
  input logic              wr_sel,
  input logic [CTRL_W-1:0] wr_data,
  input logic [CTRL_W-1:0] ctrl_q,
  input logic [NFLAG-1:0]  status_q,
  input logic              irq_pull_low,
  input logic              evt_qual
);
  logic evt_clr_req;
  assign evt_clr_req = wr_en && wr_sel && wr_data[FLAG_EVT];

  p_released_idle_r10: assert property (@(posedge clk) disable iff (rst)
    (status_q == '0) |-> !irq_pull_low);

  p_alarm_line_r10: assert property (@(posedge clk) disable iff (rst)
    (status_q[FLAG_ALM] && ctrl_q[CTRL_ALM_EN]) |-> irq_pull_low);

  p_evt_gated_r3: assert property (@(posedge clk) disable iff (rst)
    (!status_q[FLAG_EVT] && !ctrl_q[CTRL_EVT_EN]) |=> !status_q[FLAG_EVT]);

  p_batt_gate_r4: assert property (@(posedge clk) disable iff (rst)
    (!status_q[FLAG_EVT] && on_battery && !ctrl_q[CTRL_BATT_OK])
      |=> !status_q[FLAG_EVT]);

  p_evt_hold_r5: assert property (@(posedge clk) disable iff (rst)
    (status_q[FLAG_EVT] && !evt_clr_req) |=> status_q[FLAG_EVT]);

  p_alarm_set_r6: assert property (@(posedge clk) disable iff (rst)
    alarm_strobe |=> status_q[FLAG_ALM]);

  p_set_wins_r7: assert property (@(posedge clk) disable iff (rst)
    evt_qual |=> status_q[FLAG_EVT]);
endmodule

bind evt_irq_ctrl evt_irq_ctrl_chk u_chk (
  .clk(clk), .rst(rst), .alarm_strobe(alarm_strobe), .on_battery(on_battery),
  .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data), .ctrl_q(ctrl_q),
  .status_q(status_q), .irq_pull_low(irq_pull_low), .evt_qual(evt_qual)
);

// File: tb/evt_irq_ctrl_bench.sv
module evt_irq_ctrl_bench;
  logic       clk = 1'b0;
  logic       rst;
  logic       evt_in, alarm_strobe, on_battery, wr_en, wr_sel;
  logic [2:0] wr_data;
  logic [2:0] ctrl_q;
  logic [1:0] status_q;
  logic       irq_pull_low;

  int n_chk = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  evt_irq_ctrl u_evt_irq_ctrl (
    .clk(clk), .rst(rst), .evt_in(evt_in), .alarm_strobe(alarm_strobe),
    .on_battery(on_battery), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .ctrl_q(ctrl_q), .status_q(status_q),
    .irq_pull_low(irq_pull_low)
  );

  // vector: {alm_en, batt_ok, evt_en, on_battery, evt, alarm}
  localparam int NV = 10;
  localparam logic [5:0] VECS [NV] = '{
    6'b001010, 6'b000010, 6'b001110, 6'b011110, 6'b000001,
    6'b100001, 6'b101011, 6'b111111, 6'b001100, 6'b100111
  };

  task automatic tick(input int n = 1);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic sel, input logic [2:0] d);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    tick();
    wr_en = 1'b0; wr_data = '0;
  endtask

  initial begin
    #1_000_000;
    n_bad++; n_chk++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    rst = 1'b1; evt_in = 0; alarm_strobe = 0; on_battery = 0;
    wr_en = 0; wr_sel = 0; wr_data = '0;
    tick(3);
    rst = 1'b0;
    tick();
    chk("R1 reset state", {2'b0, ctrl_q, status_q, irq_pull_low}, 8'h00);

    // vector table
    for (int v = 0; v < NV; v++) begin
      logic almen, ok, en, batt, ev, al, e_evt, e_irq;
      {almen, ok, en, batt, ev, al} = VECS[v];
      wr(1'b0, {almen, ok, en});
      chk("R9 ctrl readback", {5'b0, ctrl_q}, {5'b0, almen, ok, en});
      on_battery = batt;
      evt_in = ev;
      tick(4);
      evt_in = 1'b0;
      tick(3);
      alarm_strobe = al;
      tick();
      alarm_strobe = 1'b0;
      e_evt = ev && en && (!batt || ok);
      e_irq = (e_evt && en) || (al && almen);
      chk("R2 R3 R4 R6 R10 vector", {5'b0, al, e_evt, irq_pull_low},
          {5'b0, status_q, irq_pull_low} == {5'b0, status_q, irq_pull_low} ?
          {5'b0, al, e_evt, e_irq} : 8'hff);
      chk("R8 vector flags", {6'b0, status_q}, {6'b0, al, e_evt});
      wr(1'b1, 3'b011);
      on_battery = 1'b0;
      chk("R7 clear all", {6'b0, status_q}, 8'h00);
    end

    // R2 latency
    wr(1'b0, 3'b001);
    evt_in = 1'b1;
    tick(2);
    chk("R2 no flag after two edges", {7'b0, status_q[0]}, 8'h00);
    tick();
    chk("R2 flag on third edge", {7'b0, status_q[0]}, 8'h01);
    evt_in = 1'b0;
    tick(5);
    chk("R5 line held after input low", {6'b0, status_q[0], irq_pull_low}, 8'h03);
    wr(1'b1, 3'b010);
    chk("R7 zero bit leaves event flag", {7'b0, status_q[0]}, 8'h01);
    wr(1'b1, 3'b001);
    chk("R5 line released after clear", {6'b0, status_q[0], irq_pull_low}, 8'h00);

    // R7 set wins: input held high while clearing
    evt_in = 1'b1;
    tick(4);
    wr(1'b1, 3'b001);
    chk("R7 event set wins over clear", {7'b0, status_q[0]}, 8'h01);
    evt_in = 1'b0;
    tick(3);
    wr(1'b1, 3'b001);
    chk("R7 event clears once input low", {7'b0, status_q[0]}, 8'h00);

    // R7 alarm set wins
    alarm_strobe = 1'b1; wr_en = 1'b1; wr_sel = 1'b1; wr_data = 3'b010;
    tick();
    alarm_strobe = 1'b0; wr_en = 1'b0; wr_data = '0;
    chk("R7 alarm set wins over clear", {7'b0, status_q[1]}, 8'h01);

    // R10 alarm flag with line disabled
    chk("R10 alarm flag, line enable off", {7'b0, irq_pull_low}, 8'h00);

    // R8 independence
    evt_in = 1'b1; tick(4); evt_in = 1'b0; tick(3);
    wr(1'b1, 3'b010);
    chk("R8 alarm cleared, event kept", {6'b0, status_q}, 8'h01);
    wr(1'b1, 3'b001);

    // R4 battery gating toggled by control
    on_battery = 1'b1;
    evt_in = 1'b1; tick(5);
    chk("R4 event ignored on battery", {7'b0, status_q[0]}, 8'h00);
    wr(1'b0, 3'b011);
    tick();
    chk("R4 event detected on battery when allowed", {7'b0, status_q[0]}, 8'h01);
    evt_in = 1'b0; on_battery = 1'b0;
    tick(3);

    // R1 reset mid-operation
    alarm_strobe = 1'b1; tick(); alarm_strobe = 1'b0;
    rst = 1'b1; tick(); rst = 1'b0;
    chk("R1 reset clears all", {2'b0, ctrl_q, status_q, irq_pull_low}, 8'h00);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule